// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Interrupt Detection

This block gives a processor sixteen general-purpose pins behind a small memory-mapped register bus. The bus carries 16-bit data with byte offsets. Each pin has a direction bit, and output levels are changed only through write-one-to-set and write-one-to-clear registers, so software never has to read, modify and write back the output word. Incoming pin levels pass through a two-flop synchronizer. They can then be read back, and they also feed a per-pin event detector.

Each pin's detector is a two-state machine, `PIN_QUIET` and `PIN_PENDING`. The transition named CAPTURE moves it from `PIN_QUIET` to `PIN_PENDING` when the pin's configured event is seen while its enable bit is set and no acknowledge for that pin arrives in the same cycle. The transition named ACK moves it from `PIN_PENDING` back to `PIN_QUIET` when a one is written to that pin's bit of the acknowledge register. In every other case the state holds. An event is either an active level (high or low) or an edge (rising, falling or either). A separate mask register hides pending pins from the status read and from the single combined interrupt line. Masking does not discard a pending event.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFFFF. Every other register reads 0, all pins are inputs (`pin_oe` = 0) and `irq` is low.
- R2: Direction register at offset 0x00: bit i = 1 makes pin i an output (`pin_oe[i]` = 1), and 0 makes it an input. `pin_oe` changes only on a write to 0x00.
- R3: A write to offset 0x18 sets every output-latch bit where the data has a 1. A write to 0x1C clears every such bit. Latch bits under zero data bits keep their value. The latch drives `pin_out` and reads back at 0x20. Offsets 0x18, 0x1C and 0x34 and unused offsets read as 0, and writes to read-only offsets (0x14, 0x30) have no effect.
- R4: Offset 0x14 returns the pin levels two clock edges after they are applied.
- R5: With the level-select bit (0x04) set, a pin goes pending while its synchronized level equals its polarity bit (0x08): 1 = active high, 0 = active low.
- R6: With the level-select bit clear, the rising-enable bit (0x0C) captures 0-to-1 changes and the falling-enable bit (0x10) captures 1-to-0 changes. With both bits set, either change is captured. A pin change is pending three edges after it is applied.
- R7: An event is captured only while the pin's enable bit (0x2C) is 1. An edge that occurs while the bit is 0 is lost, and it stays lost after the bit is later set.
- R8: A mask bit (0x28) of 1 removes the pin from the status read and from `irq` but keeps it pending. Clearing the mask bit reveals it.
- R9: Writing ones to offset 0x34 returns those pins to quiet at that edge, and zero bits leave the other pins unchanged. If a level-sensitive pin's active level persists, the pin is pending again one edge later.
- R10: `irq` is high exactly when some pin is pending and unmasked. Offset 0x30 returns that same set of pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output latch |
| pin_oe | output | 16 | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is the one cycle in which a level-sensitive pin has just been acknowledged but its level is still active. In that cycle both the status read and `irq` must be low, and they must come back on the very next edge. The bench reaches it with a directed sequence: it sets up a level-high pin, waits for the pending state, unmasks the pin, writes the acknowledge and samples on the next two falling edges. A similar directed sequence raises an edge while the pin's enable bit is clear and then enables the pin, to show that the old edge is not captured late. After that, a long seeded random run toggles pins, rewrites configuration and acknowledges pins while a cycle-level bench model predicts every read and output.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_AW = 8;
    typedef logic [BUS_AW-1:0] bus_addr_t;

    // register byte offsets
    localparam bus_addr_t OFS_DIR     = 8'h00;
    localparam bus_addr_t OFS_LVL_SEL = 8'h04;
    localparam bus_addr_t OFS_LVL_POL = 8'h08;
    localparam bus_addr_t OFS_RISE    = 8'h0C;
    localparam bus_addr_t OFS_FALL    = 8'h10;
    localparam bus_addr_t OFS_DIN     = 8'h14;
    localparam bus_addr_t OFS_SET     = 8'h18;
    localparam bus_addr_t OFS_CLR     = 8'h1C;
    localparam bus_addr_t OFS_DOUT    = 8'h20;
    localparam bus_addr_t OFS_MASK    = 8'h28;
    localparam bus_addr_t OFS_ENABLE  = 8'h2C;
    localparam bus_addr_t OFS_STATUS  = 8'h30;
    localparam bus_addr_t OFS_ACK     = 8'h34;

    typedef enum logic {
        PIN_QUIET   = 1'b0,
        PIN_PENDING = 1'b1
    } pin_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
            prev_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
            prev_q <= chain_q[LAST];
        end
    end

    assign sync_o = chain_q[LAST];
    assign prev_o = prev_q;

    // the delayed copy always trails the synchronized value by one edge (R6)
    assert_prev_trails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(sync_o)));

endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now_i,
    input  logic lvl_prev_i,
    input  logic lvl_sel_i,
    input  logic lvl_pol_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic en_i,
    input  logic ack_i,
    output logic pend_o
);
    pin_state_e state_q, state_d;
    logic       hit;

    // event qualification
    always_comb begin
        if (lvl_sel_i) begin
            hit = (lvl_now_i == lvl_pol_i);
        end else begin
            hit = (rise_i && lvl_now_i && !lvl_prev_i) ||
                  (fall_i && !lvl_now_i && lvl_prev_i);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_QUIET;
        else        state_q <= state_d;
    end

    // next state: CAPTURE and ACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_QUIET: begin
                if (hit && en_i && !ack_i) state_d = PIN_PENDING;
            end
            PIN_PENDING: begin
                if (ack_i) state_d = PIN_QUIET;
            end
            default: state_d = PIN_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        pend_o = (state_q == PIN_PENDING);
    end

    assert_no_capture_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_QUIET && !en_i) |=> (state_q == PIN_QUIET));

    assert_ack_returns_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (state_q == PIN_QUIET));

    assert_pending_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_PENDING && !ack_i) |=> (state_q == PIN_PENDING));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  bus_addr_t       bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] din_i,
    input  logic [NPIN-1:0] pend_i,
    output logic [NPIN-1:0] dir_o,
    output logic [NPIN-1:0] lvl_sel_o,
    output logic [NPIN-1:0] lvl_pol_o,
    output logic [NPIN-1:0] rise_o,
    output logic [NPIN-1:0] fall_o,
    output logic [NPIN-1:0] dout_o,
    output logic [NPIN-1:0] mask_o,
    output logic [NPIN-1:0] en_o,
    output logic [NPIN-1:0] ack_o
);
    localparam logic [NPIN-1:0] ALL_ONES = {NPIN{1'b1}};

    logic [NPIN-1:0] dir_q, sel_q, pol_q, rise_q, fall_q, dout_q, mask_q, en_q;
    logic            wr_dir, wr_sel, wr_pol, wr_rise, wr_fall;
    logic            wr_set, wr_clr, wr_mask, wr_en, wr_ack;

    always_comb begin
        wr_dir  = bus_wr && (bus_addr == OFS_DIR);
        wr_sel  = bus_wr && (bus_addr == OFS_LVL_SEL);
        wr_pol  = bus_wr && (bus_addr == OFS_LVL_POL);
        wr_rise = bus_wr && (bus_addr == OFS_RISE);
        wr_fall = bus_wr && (bus_addr == OFS_FALL);
        wr_set  = bus_wr && (bus_addr == OFS_SET);
        wr_clr  = bus_wr && (bus_addr == OFS_CLR);
        wr_mask = bus_wr && (bus_addr == OFS_MASK);
        wr_en   = bus_wr && (bus_addr == OFS_ENABLE);
        wr_ack  = bus_wr && (bus_addr == OFS_ACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            sel_q  <= '0;
            pol_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            dout_q <= '0;
            mask_q <= ALL_ONES;
            en_q   <= '0;
        end else begin
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_sel)  sel_q  <= bus_wdata;
            if (wr_pol)  pol_q  <= bus_wdata;
            if (wr_rise) rise_q <= bus_wdata;
            if (wr_fall) fall_q <= bus_wdata;
            if (wr_mask) mask_q <= bus_wdata;
            if (wr_en)   en_q   <= bus_wdata;
            if (wr_set)       dout_q <= dout_q | bus_wdata;
            else if (wr_clr)  dout_q <= dout_q & ~bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DIR:     bus_rdata = dir_q;
            OFS_LVL_SEL: bus_rdata = sel_q;
            OFS_LVL_POL: bus_rdata = pol_q;
            OFS_RISE:    bus_rdata = rise_q;
            OFS_FALL:    bus_rdata = fall_q;
            OFS_DIN:     bus_rdata = din_i;
            OFS_DOUT:    bus_rdata = dout_q;
            OFS_MASK:    bus_rdata = mask_q;
            OFS_ENABLE:  bus_rdata = en_q;
            OFS_STATUS:  bus_rdata = pend_i & ~mask_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign dir_o     = dir_q;
    assign lvl_sel_o = sel_q;
    assign lvl_pol_o = pol_q;
    assign rise_o    = rise_q;
    assign fall_o    = fall_q;
    assign dout_o    = dout_q;
    assign mask_o    = mask_q;
    assign en_o      = en_q;
    assign ack_o     = wr_ack ? bus_wdata : '0;

    assert_set_bits_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((dout_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clr_bits_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((dout_q & $past(bus_wdata)) == '0));

    assert_untouched_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=>
            ((dout_q & ~$past(bus_wdata)) == ($past(dout_q) & ~$past(bus_wdata))));

    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq
);
    logic [NPIN-1:0] lvl_now, lvl_prev, pend;
    logic [NPIN-1:0] dir_w, sel_w, pol_w, rise_w, fall_w, dout_w, mask_w, en_w, ack_w;

    gpio_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (lvl_now),
        .prev_o (lvl_prev)
    );

    gpio_regs #(.NPIN(NPIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .din_i    (lvl_now),
        .pend_i   (pend),
        .dir_o    (dir_w),
        .lvl_sel_o(sel_w),
        .lvl_pol_o(pol_w),
        .rise_o   (rise_w),
        .fall_o   (fall_w),
        .dout_o   (dout_w),
        .mask_o   (mask_w),
        .en_o     (en_w),
        .ack_o    (ack_w)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_pin_irq u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_now_i (lvl_now[i]),
            .lvl_prev_i(lvl_prev[i]),
            .lvl_sel_i (sel_w[i]),
            .lvl_pol_i (pol_w[i]),
            .rise_i    (rise_w[i]),
            .fall_i    (fall_w[i]),
            .en_i      (en_w[i]),
            .ack_i     (ack_w[i]),
            .pend_o    (pend[i])
        );
    end

    assign pin_out = dout_w;
    assign pin_oe  = dir_w;
    assign irq     = |(pend & ~mask_w);

    assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == {NPIN{1'b1}}) |-> !irq);

    assert_irq_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0));

endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
    localparam int N = 16;
    localparam logic [7:0] A_DIR = 8'h00, A_SEL = 8'h04, A_POL = 8'h08, A_RISE = 8'h0C,
        A_FALL = 8'h10, A_DIN = 8'h14, A_SET = 8'h18, A_CLR = 8'h1C, A_DOUT = 8'h20,
        A_MASK = 8'h28, A_EN = 8'h2C, A_STAT = 8'h30, A_ACK = 8'h34;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pins = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // bench model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_prev, m_pend;
    logic [N-1:0] m_dir, m_sel, m_pol, m_rise, m_fall, m_dout, m_mask, m_en;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0;
            m_dir <= '0; m_sel <= '0; m_pol <= '0; m_rise <= '0; m_fall <= '0;
            m_dout <= '0; m_mask <= '1; m_en <= '0;
        end else begin
            logic [N-1:0] ev, ack;
            ev  = (m_sel & ~(m_s2 ^ m_pol)) |
                  (~m_sel & ((m_rise & m_s2 & ~m_prev) | (m_fall & ~m_s2 & m_prev)));
            ack = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;
            m_pend <= (m_pend | (ev & m_en)) & ~ack;
            m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
            if (bus_wr) begin
                case (bus_addr)
                    A_DIR:  m_dir  <= bus_wdata;
                    A_SEL:  m_sel  <= bus_wdata;
                    A_POL:  m_pol  <= bus_wdata;
                    A_RISE: m_rise <= bus_wdata;
                    A_FALL: m_fall <= bus_wdata;
                    A_SET:  m_dout <= m_dout | bus_wdata;
                    A_CLR:  m_dout <= m_dout & ~bus_wdata;
                    A_MASK: m_mask <= bus_wdata;
                    A_EN:   m_en   <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [N-1:0] model_read(input logic [7:0] a);
        case (a)
            A_DIR:  return m_dir;
            A_SEL:  return m_sel;
            A_POL:  return m_pol;
            A_RISE: return m_rise;
            A_FALL: return m_fall;
            A_DIN:  return m_s2;
            A_DOUT: return m_dout;
            A_MASK: return m_mask;
            A_EN:   return m_en;
            A_STAT: return m_pend & ~m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock, then compare outputs against the model
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check("R10 irq", {15'b0, irq}, {15'b0, |(m_pend & ~m_mask)});
        check("R2 pin_oe", pin_oe, m_dir);
        check("R3 pin_out", pin_out, m_dout);
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [N-1:0] exp, input string tag);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        check({tag, " model"}, bus_rdata, model_read(a));
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        logic [7:0] addrs [15];
        addrs = '{A_DIR, A_SEL, A_POL, A_RISE, A_FALL, A_DIN, A_SET, A_CLR, A_DOUT,
                  A_MASK, A_EN, A_STAT, A_ACK, 8'h24, 8'h3C};
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_MASK, 16'hFFFF, "R1 mask");
        rd(A_DIR, 16'h0000, "R1 dir");
        rd(A_EN, 16'h0000, "R1 enable");
        rd(A_STAT, 16'h0000, "R1 status");
        check("R1 irq", {15'b0, irq}, 16'h0000);
        check("R1 pin_oe", pin_oe, 16'h0000);

        // R2, R3 direction and atomic output updates
        wr(A_DIR, 16'h00F0);
        check("R2 oe", pin_oe, 16'h00F0);
        wr(A_SET, 16'h0011);
        check("R3 set", pin_out, 16'h0011);
        rd(A_DOUT, 16'h0011, "R3 dout read");
        rd(A_SET, 16'h0000, "R3 set reads zero");
        wr(A_SET, 16'h0100);
        check("R3 set keeps others", pin_out, 16'h0111);
        wr(A_CLR, 16'h0001);
        check("R3 clear", pin_out, 16'h0110);
        rd(A_CLR, 16'h0000, "R3 clear reads zero");
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, 16'h0000, "R3 read-only status write ignored");

        // R4 synchronizer latency
        pins = 16'hA5A5;
        step();
        rd(A_DIN, 16'h0000, "R4 one edge");
        step();
        rd(A_DIN, 16'hA5A5, "R4 two edges");

        // R5, R8, R9 level-high pin 0
        wr(A_EN, 16'h0001);
        wr(A_SEL, 16'h0001);
        wr(A_POL, 16'h0001);
        step();
        rd(A_STAT, 16'h0000, "R8 masked pending hidden");
        check("R8 masked irq", {15'b0, irq}, 16'h0000);
        wr(A_MASK, 16'hFFFE);
        check("R8 unmask reveals", {15'b0, irq}, 16'h0001);
        rd(A_STAT, 16'h0001, "R5 level high pending");
        wr(A_ACK, 16'h0000);
        rd(A_STAT, 16'h0001, "R9 zero ack keeps");
        wr(A_ACK, 16'h0001);
        rd(A_STAT, 16'h0000, "R9 ack clears");
        check("R9 irq low after ack", {15'b0, irq}, 16'h0000);
        step();
        rd(A_STAT, 16'h0001, "R9 level re-pends");
        wr(A_SEL, 16'h0000);
        wr(A_POL, 16'h0000);
        wr(A_ACK, 16'h0001);
        step();
        rd(A_STAT, 16'h0000, "R6 no edge enable no pending");

        // R6, R7 edges on pin 1
        wr(A_RISE, 16'h0002);
        wr(A_FALL, 16'h0002);
        wr(A_MASK, 16'hFFFC);
        pins[1] = 1'b1;
        wait_n(4);
        rd(A_STAT, 16'h0000, "R7 disabled edge lost");
        wr(A_EN, 16'h0003);
        wait_n(3);
        rd(A_STAT, 16'h0000, "R7 late enable no capture");
        pins[1] = 1'b0;
        wait_n(2);
        rd(A_STAT, 16'h0000, "R6 not yet pending");
        step();
        rd(A_STAT, 16'h0002, "R6 falling with both");
        wr(A_ACK, 16'h0002);
        wr(A_FALL, 16'h0000);
        pins[1] = 1'b1;
        wait_n(3);
        rd(A_STAT, 16'h0002, "R6 rising");
        wr(A_ACK, 16'h0002);
        pins[1] = 1'b0;
        wait_n(3);
        rd(A_STAT, 16'h0000, "R6 falling ignored when rise only");

        // R5 level-low pin 2 (pin high now)
        wr(A_SEL, 16'h0004);
        wr(A_EN, 16'h0004);
        wr(A_MASK, 16'hFFFB);
        step();
        rd(A_STAT, 16'h0000, "R5 low level inactive");
        pins[2] = 1'b0;
        wait_n(3);
        rd(A_STAT, 16'h0004, "R5 low level pending");

        // random phase, model checked
        for (int it = 0; it < 3000; it++) begin
            logic [7:0] a;
            int pick;
            if ($urandom_range(3, 0) == 0) pins = pins ^ N'($urandom & $urandom & $urandom);
            a = addrs[$urandom_range(14, 0)];
            pick = $urandom_range(9, 0);
            if (pick < 3) begin
                bus_wr = 1'b1; bus_addr = a; bus_wdata = N'($urandom);
            end else if (pick == 3) begin
                bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = N'($urandom);
            end else begin
                bus_wr = 1'b0; bus_addr = a;
                #1;
                check("R10 random read", bus_rdata, model_read(a));
            end
            step();
            bus_wr = 1'b0;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule